// File: doc/BRIEF.md
# Configuration Boot Loader

This block runs the download phase of a configurable processor: it fills the processor's internal configuration storage one byte at a time. In automatic mode it walks a 12-bit address across an external byte-wide memory, advancing at a rate set by a divided clock, captures the byte that comes back, and writes it through a one-cycle write port. It raises an end-of-load flag when the programmed number of words has been stored. In manual mode a host supplies the bytes with an RD/READY handshake, and each byte goes to the next write address.

The offline line enables the whole phase. Any change on that line puts the block into a short, fixed reset hold before it acts again. Once the hold ends, the block latches the mode, the speed select and the word count. Changes to those inputs during a load have no effect.

Top module: `cfg_boot_loader`

## Requirements
- R1: Any change of `offline_i` holds the block in reset for 3 clock cycles, with `ext_addr_o`=0 and `wr_en_o`, `ready_o` and `load_done_o` low. If the change falls between rising edges k-1 and k, the loader takes its first step on edge k+3.
- R2: In automatic mode (`auto_i`=1 at the first step), `ext_addr_o` presents 0, 1, ..., N-1. Each address is held for D clocks, starting at the first step. D is 16 when `speed_sel_i[0]`=1 and 32 when it is 0; bits 2:1 are ignored.
- R3: The byte for address a is captured at the word's midpoint, on edge S+a·D+D/2, where S is the first-step edge. At that edge `wr_en_o` pulses high for one cycle with `wr_addr_o`=a and `wr_data_o` equal to `data_i`. No other writes occur.
- R4: `load_done_o` rises on edge S+N·D, issues no further writes, and stays high until `offline_i` changes.
- R5: A word count of zero raises `load_done_o` on the first-step edge, with no write and `ext_addr_o` left at 0.
- R6: A word count above 2436 is treated as 2436.
- R7: Mode, speed select and word count are latched at the first step; changing them during a load has no effect.
- R8: In manual mode (`auto_i`=0 at the first step), each rising edge of `rd_i` that is seen while the block is waiting captures `data_i`. The byte is written to consecutive addresses from 0, and `ext_addr_o` shows the index of the next byte. `load_done_o` stays low.
- R9: `ready_o` rises 3 clocks after the edge that captured a byte. It falls on the edge after `rd_i` is seen low. An `rd_i` rise before `ready_o` has been released is ignored.
- R10: While `offline_i` is low, no write, READY or end flag occurs, whatever `rd_i` and `auto_i` do.
- R11: During and after `rst_ni` low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offline_i | input | 1 | Download phase enable |
| auto_i | input | 1 | 1 = automatic load, 0 = manual handshake |
| speed_sel_i | input | 3 | Speed select; bit 0 picks the divide factor |
| data_i | input | 8 | Byte from the external memory or host |
| word_cnt_i | input | 12 | Number of words to load in automatic mode |
| rd_i | input | 1 | Manual-mode data strobe, active high |
| ext_addr_o | output | 12 | External memory address / next byte index |
| wr_en_o | output | 1 | Configuration storage write strobe |
| wr_addr_o | output | 12 | Configuration storage write address |
| wr_data_o | output | 8 | Configuration storage write data |
| ready_o | output | 1 | Manual-mode acknowledge, active high |
| load_done_o | output | 1 | End of load flag |

## Verification
The assertions check the cycle-level invariants on every clock:
- outputs stay quiet during the hold and while offline is low;
- the address changes only by single steps;
- every write pulse lasts one cycle and lands below the latched count and the 2436 limit;
- the end flag stays set and blocks writes;
- READY is released after RD drops.

Only the bench scenarios can show the exact timing of the first step, the midpoint sample edge, and the D·N load length for both divide factors. The same applies to the clamp at 2436, the immunity to mid-load changes of the configuration inputs, and the three-clock acknowledge delay. The bench also shows that an early RD rise does not produce a second write.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_AUTO,
    LD_MAN,
    LD_DONE
  } ld_state_e;

  typedef enum logic [1:0] {
    HS_WAIT,
    HS_ACK,
    HS_HOLD
  } hs_state_e;

endpackage

// File: rtl/cbl_hold_gen.sv
module cbl_hold_gen #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic offline_i,
  output logic held_o,
  output logic level_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic          off_q;
  logic [HW-1:0] cnt_q;
  logic          toggle;

  assign toggle  = offline_i ^ off_q;
  assign held_o  = toggle | (cnt_q != '0);
  assign level_o = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      off_q <= offline_i;
      if (toggle)             cnt_q <= HW'(HOLD_CYC - 1);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cbl_word_timer.sv
module cbl_word_timer #(
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic sample_o,
  output logic wrap_o
);
  localparam int PH_W = $clog2(SLOW_DIV);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] mid_ph;

  assign last_ph  = fast_i ? PH_W'(FAST_DIV - 1) : PH_W'(SLOW_DIV - 1);
  assign mid_ph   = fast_i ? PH_W'(FAST_DIV / 2 - 1) : PH_W'(SLOW_DIV / 2 - 1);
  assign sample_o = run_i && (ph_q == mid_ph);
  assign wrap_o   = run_i && (ph_q == last_ph);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (!run_i)  ph_q <= '0;
    else if (wrap_o)  ph_q <= '0;
    else              ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/cbl_rd_hs.sv
module cbl_rd_hs
  import cbl_pkg::*;
#(
  parameter int RDY_LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rd_i,
  output logic take_o,
  output logic ready_o
);
  localparam int CW = $clog2(RDY_LAT + 1);

  hs_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          rd_q;

  assign take_o = en_i && (st_q == HS_WAIT) && rd_i && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= HS_WAIT;
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (!en_i) begin
      st_q    <= HS_WAIT;
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else begin
      unique case (st_q)
        HS_WAIT: if (take_o) begin
          st_q  <= HS_ACK;
          cnt_q <= CW'(RDY_LAT - 1);
        end
        HS_ACK: begin
          if (cnt_q == '0) begin
            ready_o <= 1'b1;
            st_q    <= HS_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        HS_HOLD: if (!rd_i) begin
          ready_o <= 1'b0;
          st_q    <= HS_WAIT;
        end
        default: st_q <= HS_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cbl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int MAX_WORDS = 2436,
  parameter int HOLD_CYC  = 3,
  parameter int RDY_LAT   = 3,
  parameter int FAST_DIV  = 16,
  parameter int SLOW_DIV  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              offline_i,
  input  logic              auto_i,
  input  logic [2:0]        speed_sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] word_cnt_i,
  input  logic              rd_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              ready_o,
  output logic              load_done_o
);
  localparam logic [ADDR_W-1:0] CNT_MAX = ADDR_W'(MAX_WORDS);

  ld_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] eff_cnt;
  logic              fast_q;
  logic              held;
  logic              off_lvl;
  logic              sample;
  logic              wrap;
  logic              take;
  logic              auto_run;

  assign eff_cnt  = (word_cnt_i > CNT_MAX) ? CNT_MAX : word_cnt_i;
  assign auto_run = (state_q == LD_AUTO);

  cbl_hold_gen #(.HOLD_CYC(HOLD_CYC)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .offline_i(offline_i),
    .held_o   (held),
    .level_o  (off_lvl)
  );

  cbl_word_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (auto_run && !held),
    .fast_i  (fast_q),
    .sample_o(sample),
    .wrap_o  (wrap)
  );

  cbl_rd_hs #(.RDY_LAT(RDY_LAT)) i_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   ((state_q == LD_MAN) && !held),
    .rd_i   (rd_i),
    .take_o (take),
    .ready_o(ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LD_IDLE;
      addr_q    <= '0;
      cnt_q     <= '0;
      fast_q    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (held) begin
      state_q   <= LD_IDLE;
      addr_q    <= '0;
      cnt_q     <= '0;
      fast_q    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      unique case (state_q)
        LD_IDLE: if (off_lvl) begin
          if (auto_i) begin
            fast_q  <= speed_sel_i[0];
            cnt_q   <= eff_cnt;
            state_q <= (eff_cnt == '0) ? LD_DONE : LD_AUTO;
          end else begin
            state_q <= LD_MAN;
          end
        end
        LD_AUTO: begin
          if (sample) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= addr_q;
            wr_data_o <= data_i;
          end
          if (wrap) begin
            if (addr_q == cnt_q - 1'b1) state_q <= LD_DONE;
            else                        addr_q  <= addr_q + 1'b1;
          end
        end
        LD_MAN: if (take) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= addr_q;
          wr_data_o <= data_i;
          addr_q    <= addr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ext_addr_o  = addr_q;
  assign load_done_o = (state_q == LD_DONE);
endmodule

// File: rtl/cbl_boot_loader_chk.sv
module cbl_boot_loader_chk #(
  parameter int ADDR_W    = 12,
  parameter int MAX_WORDS = 2436
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              held_i,
  input logic              auto_run_i,
  input logic [ADDR_W-1:0] cnt_i,
  input logic              offline_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] ext_addr_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              ready_o,
  input logic              load_done_o
);
  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i && $past(held_i) |-> !wr_en_o && !ready_o && !load_done_o && ext_addr_o == '0); // R1

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(held_i) && ext_addr_o != $past(ext_addr_o) |-> ext_addr_o == ADDR_W'($past(ext_addr_o) + 1'b1)); // R2

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_run_i && wr_en_o |-> wr_addr_o < cnt_i); // R3

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_done_o) && !$past(held_i) |-> load_done_o); // R4

  AST_DONE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_done_o) |-> !wr_en_o); // R4

  AST_CLAMP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_run_i && wr_en_o |-> wr_addr_o < ADDR_W'(MAX_WORDS)); // R6

  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R8

  AST_READY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !rd_i |=> !ready_o); // R9

  AST_OFFLINE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !offline_i && !held_i |-> !wr_en_o && !load_done_o && !ready_o); // R10
endmodule

bind cfg_boot_loader cbl_boot_loader_chk #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .held_i     (held),
  .auto_run_i (auto_run),
  .cnt_i      (cnt_q),
  .offline_i  (offline_i),
  .rd_i       (rd_i),
  .ext_addr_o (ext_addr_o),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .ready_o    (ready_o),
  .load_done_o(load_done_o)
);

// File: tb/test_cfg_boot_loader.sv
module test_cfg_boot_loader;
  localparam int CLK_PERIOD = 10;
  localparam int S = 4;  // first-step edge after an offline change

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        offline_i = 1'b0;
  logic        auto_i = 1'b1;
  logic [2:0]  speed_sel_i = '0;
  logic [7:0]  data_i;
  logic [11:0] word_cnt_i = '0;
  logic        rd_i = 1'b0;
  logic [11:0] ext_addr_o;
  logic        wr_en_o;
  logic [11:0] wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        ready_o;
  logic        load_done_o;

  logic        man_sel = 1'b0;
  logic [7:0]  man_byte = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          wr_seen = 0;
  bit          finished = 1'b0;

  // spd[32:30] cnt[29:18] exp_n[17:6] exp_div[5:0]
  localparam int NV = 6;
  localparam logic [32:0] VEC [NV] = '{
    {3'b001, 12'd3,    12'd3,    6'd16},
    {3'b000, 12'd2,    12'd2,    6'd32},
    {3'b111, 12'd1,    12'd1,    6'd16},
    {3'b110, 12'd2,    12'd2,    6'd32},
    {3'b001, 12'd0,    12'd0,    6'd16},
    {3'b101, 12'd3000, 12'd2436, 6'd16}
  };

  function automatic logic [7:0] mem_f(input logic [11:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[11:8], 4'h0};
  endfunction

  assign data_i = man_sel ? man_byte : mem_f(ext_addr_o);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  always @(negedge clk_i) if (wr_en_o) wr_seen++;

  cfg_boot_loader i_cfg_boot_loader (
    .clk_i, .rst_ni, .offline_i, .auto_i, .speed_sel_i, .data_i, .word_cnt_i, .rd_i,
    .ext_addr_o, .wr_en_o, .wr_addr_o, .wr_data_o, .ready_o, .load_done_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic man_xfer(input logic [7:0] b, input int idx);
    int w0;
    w0 = wr_seen;
    man_byte = b;
    rd_i = 1'b1;
    step();
    chk(wr_en_o && wr_addr_o == 12'(idx) && wr_data_o == b, "R8", {wr_en_o, wr_addr_o, wr_data_o}, {1'b1, 12'(idx), b});
    chk(ext_addr_o == 12'(idx + 1), "R8", ext_addr_o, idx + 1);
    step();
    step();
    chk(!ready_o, "R9", ready_o, 0);
    step();
    chk(ready_o, "R9", ready_o, 1);
    rd_i = 1'b0;
    step();
    chk(!ready_o, "R9", ready_o, 0);
    #1;
    chk(wr_seen == w0 + 1, "R8", wr_seen - w0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk_i);
    chk(!wr_en_o && !ready_o && !load_done_o && ext_addr_o == 0 && wr_addr_o == 0 && wr_data_o == 0,
        "R11", {wr_en_o, ready_o, load_done_o, ext_addr_o}, 0);
    step();
    rst_ni = 1'b1;
    step();
    chk(!wr_en_o && !ready_o && !load_done_o && ext_addr_o == 0, "R11", {wr_en_o, ready_o, load_done_o}, 0);

    // R2 R3 R4 R5 R6 R7: table of automatic loads
    for (int v = 0; v < NV; v++) begin
      logic [2:0] spd;
      int n, dv, half, last;
      spd  = VEC[v][32:30];
      n    = int'(VEC[v][17:6]);
      dv   = int'(VEC[v][5:0]);
      half = dv / 2;
      last = S + n * dv;
      auto_i = 1'b1;
      speed_sel_i = spd;
      word_cnt_i = VEC[v][29:18];
      offline_i = 1'b1;
      for (int c = 1; c <= last + 2; c++) begin
        step();
        if (c == S + 2) begin
          speed_sel_i = ~spd;
          word_cnt_i  = 12'hFFF;
          auto_i      = 1'b0;
        end
        if (c < S)
          chk(!wr_en_o && ext_addr_o == 0 && !load_done_o, "R1", {wr_en_o, ext_addr_o, load_done_o}, 0);
        if (n != 0 && c >= S + half && ((c - S - half) % dv) == 0 && ((c - S - half) / dv) < n) begin
          int w;
          w = (c - S - half) / dv;
          chk(wr_en_o && wr_addr_o == 12'(w) && wr_data_o == mem_f(12'(w)), (c > S + 2) ? "R7" : "R3",
              {wr_en_o, wr_addr_o, wr_data_o}, {1'b1, 12'(w), mem_f(12'(w))});
        end else if (wr_en_o) begin
          chk(1'b0, "R3", {wr_en_o, wr_addr_o}, 0);
        end
        if (c >= S && c < last && ((c - S) % dv) == 0)
          chk(ext_addr_o == 12'((c - S) / dv), (c > S + 2) ? "R7" : "R2", ext_addr_o, (c - S) / dv);
        if (n != 0 && c == last - 1)
          chk(!load_done_o, "R4", load_done_o, 0);
        if (c == last)
          chk(load_done_o, (n == 0) ? "R5" : ((v == 5) ? "R6" : "R4"), load_done_o, 1);
      end
      repeat (20) step();
      chk(load_done_o, "R4", load_done_o, 1);
      if (n == 0) chk(ext_addr_o == 0 && wr_seen >= 0, "R5", ext_addr_o, 0);
      offline_i = 1'b0;
      step();
      chk(!load_done_o && ext_addr_o == 0 && !wr_en_o, "R1", {load_done_o, ext_addr_o}, 0);
      repeat (5) step();
    end

    // R1: offline dropped mid-load restarts from address 0
    auto_i = 1'b1;
    speed_sel_i = 3'b001;
    word_cnt_i = 12'd5;
    offline_i = 1'b1;
    repeat (S + 30) step();
    chk(ext_addr_o == 12'd1, "R2", ext_addr_o, 1);
    offline_i = 1'b0;
    step();
    chk(ext_addr_o == 0 && !wr_en_o && !load_done_o, "R1", ext_addr_o, 0);
    step();
    offline_i = 1'b1;
    for (int c = 1; c <= S + 8; c++) begin
      step();
      if (c < S + 8) chk(!wr_en_o, "R1", wr_en_o, 0);
    end
    chk(wr_en_o && wr_addr_o == 0, "R1", {wr_en_o, wr_addr_o}, {1'b1, 12'd0});
    offline_i = 1'b0;
    repeat (6) step();

    // R10: offline low, strobes ignored
    begin
      int w0;
      w0 = wr_seen;
      auto_i = 1'b1;
      word_cnt_i = 12'd1;
      for (int k = 0; k < 4; k++) begin
        rd_i = 1'b1;
        repeat (5) step();
        chk(!ready_o && !load_done_o, "R10", {ready_o, load_done_o}, 0);
        rd_i = 1'b0;
        repeat (5) step();
      end
      auto_i = 1'b0;
      rd_i = 1'b1;
      repeat (5) step();
      rd_i = 1'b0;
      step();
      chk(wr_seen == w0, "R10", wr_seen - w0, 0);
    end

    // R8 R9: manual handshake
    man_sel = 1'b1;
    auto_i = 1'b0;
    offline_i = 1'b1;
    repeat (S + 2) step();
    chk(ext_addr_o == 0 && !ready_o, "R8", ext_addr_o, 0);
    man_xfer(8'h3C, 0);
    step();
    man_xfer(8'hC7, 1);
    step();
    // R9: early second rise ignored
    begin
      int w0;
      w0 = wr_seen;
      man_byte = 8'h5E;
      rd_i = 1'b1;
      step();
      rd_i = 1'b0;
      step();
      man_byte = 8'hFF;
      rd_i = 1'b1;
      step();
      step();
      chk(ready_o, "R9", ready_o, 1);
      repeat (3) step();
      chk(ready_o, "R9", ready_o, 1);
      rd_i = 1'b0;
      step();
      chk(!ready_o, "R9", ready_o, 0);
      #1;
      chk(wr_seen == w0 + 1 && ext_addr_o == 12'd3, "R9", wr_seen - w0, 1);
      chk(!load_done_o, "R8", load_done_o, 0);
    end
    @(negedge clk_i);
    offline_i = 1'b0;
    repeat (6) step();
    finish_run();
  end
endmodule